// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Sequencer

This block keeps the two threshold offsets that a FIFO's partial-fullness flag logic compares against: one offset for the almost-empty flag and one for the almost-full flag. Each offset is 13 bits wide. It is held as an 8-bit low byte and a 5-bit high field, so it can name any of 8192 locations. Both offsets are driven continuously to the flag logic, which lies outside this block.

Software reaches the four fields through one 8-bit data port. A load-select input, held low, steers the FIFO ports to the offset registers. On the write side, an active-low write enable stores the input byte into the field that a rotating write pointer selects, and then moves the pointer on. On the read side, two active-low read enables, both low, copy the field that an independent rotating read pointer selects into the output register. The field order is always the same: empty low byte, empty high bits, full low byte, full high bits. Neither pointer returns to the start when a session ends early, so a later session carries on from the next field. Both ports share one clock, which is the single-clock arrangement of the FIFO.

Top module: `ofs_seq`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), emptyOffset and fullOffset are both 7 (low bytes 07h, high fields 0), dataOut is 0, conflictErr is 0, and both pointers select the empty low byte.
- R2: A write is an edge with ldN=0 and wrEnN=0. It stores into the selected field, visible on the offset outputs after that edge, and advances the write pointer. Field order: 0 = empty low byte (dataIn[7:0] becomes emptyOffset[7:0]), 1 = empty high bits (dataIn[4:0] becomes emptyOffset[12:8]), 2 = full low byte (fullOffset[7:0]), 3 = full high bits (fullOffset[12:8]).
- R3: The write after a write to field 3 targets field 0 again.
- R4: An edge with ldN=0 and wrEnN=1, or with ldN=1 whatever wrEnN is, changes no offset and does not move the write pointer.
- R5: A session that stops after some fields (ldN returns high) resumes at the next field in order when loading starts again.
- R6: A read is an edge with ldN=0, rdEnAN=0 and rdEnBN=0. It loads dataOut with the field the read pointer selects, zero-extended to 8 bits, and advances the read pointer in the R2 order. The pointer wraps from field 3 to field 0 and runs independently of the write pointer.
- R7: With either read enable high, or with ldN high, dataOut holds its value and the read pointer holds its position.
- R8: A write and a read requested at the same edge perform the write only. dataOut and the read pointer hold, and conflictErr is high for the one cycle after that edge. Otherwise conflictErr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both the write port and the read port |
| rstN | input | 1 | Active-low synchronous reset |
| ldN | input | 1 | Active-low select that routes both ports to the offset fields |
| wrEnN | input | 1 | Active-low write enable |
| dataIn | input | 8 | Field write data; the high fields use bits 4:0 |
| rdEnAN | input | 1 | Active-low read enable, first of two |
| rdEnBN | input | 1 | Active-low read enable, second of two |
| dataOut | output | 8 | Registered field read-back |
| emptyOffset | output | 13 | Almost-empty threshold offset |
| fullOffset | output | 13 | Almost-full threshold offset |
| conflictErr | output | 1 | High for one cycle after a simultaneous write and read request |

## Verification
The hard states to reach are the ones where the two pointers stand at different fields. One example is a read-back that begins after a partial load has left the write pointer in the middle of the sequence. Another is a collision edge that must advance the write pointer but freeze the read pointer. The stimulus table interleaves partial load sessions, idle edges, single-enable reads and a collision, so that the pointers drift apart. A model in the bench tracks both pointers and all four fields and predicts every output after every edge. Directed runs then cover reset in the middle of a sequence and the clearing of the conflict flag.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  // Field order is behaviour: both pointers step through it in this sequence.
  typedef enum logic [1:0] {
    FLD_EMPTY_LO = 2'd0,
    FLD_EMPTY_HI = 2'd1,
    FLD_FULL_LO  = 2'd2,
    FLD_FULL_HI  = 2'd3
  } fieldSel_e;

  localparam int NUM_FIELDS = 4;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic      wrStb;
    logic      rdStb;
    fieldSel_e wrSel;
    fieldSel_e rdSel;
  } ofsStrobe_t;

endpackage

// File: rtl/ofs_seq_ctrl.sv
module ofs_seq_ctrl
  import ofs_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldN,
  input  logic       wrEnN,
  input  logic       rdEnAN,
  input  logic       rdEnBN,
  output ofsStrobe_t strb,
  output logic       conflictErr
);

  logic      wrReq;
  logic      rdReq;
  fieldSel_e wrPtr;
  fieldSel_e rdPtr;

  function automatic fieldSel_e stepSel(input fieldSel_e cur);
    return fieldSel_e'(2'(cur) + 2'd1);
  endfunction

  always_comb begin
    wrReq = !ldN && !wrEnN;
    rdReq = !ldN && !rdEnAN && !rdEnBN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= FLD_EMPTY_LO;
      rdPtr       <= FLD_EMPTY_LO;
      conflictErr <= 1'b0;
    end else begin
      if (wrReq) wrPtr <= stepSel(wrPtr);
      // On a collision the write wins and the read is dropped.
      if (rdReq && !wrReq) rdPtr <= stepSel(rdPtr);
      conflictErr <= wrReq && rdReq;
    end
  end

  always_comb begin
    strb.wrStb = wrReq;
    strb.rdStb = rdReq && !wrReq;
    strb.wrSel = wrPtr;
    strb.rdSel = rdPtr;
  end

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && rdReq) |=> (conflictErr && $stable(rdPtr))); // R8
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (wrPtr != $past(wrPtr))); // R2
  AST_WR_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> $stable(wrPtr)); // R5
  AST_RD_PARK: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(rdPtr)); // R7

endmodule

// File: rtl/ofs_seq_dpath.sv
module ofs_seq_dpath
  import ofs_seq_pkg::*;
#(
  parameter int LO_W    = 8,
  parameter int HI_W    = 5,
  parameter int DEF_OFS = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ofsStrobe_t           strb,
  input  logic [LO_W-1:0]      dataIn,
  output logic [LO_W-1:0]      dataOut,
  output logic [LO_W+HI_W-1:0] emptyOffset,
  output logic [LO_W+HI_W-1:0] fullOffset
);

  localparam int OFS_W = LO_W + HI_W;

  logic [LO_W-1:0] fieldVal [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    // Even fields are low bytes, odd fields are high bits.
    localparam int FW   = (g % 2 == 0) ? LO_W : HI_W;
    localparam int DEFV = (g % 2 == 0) ? DEF_OFS : 0;
    logic [FW-1:0] q;

    always_ff @(posedge clk) begin
      if (!rstN) q <= FW'(DEFV);
      else if (strb.wrStb && (strb.wrSel == 2'(g))) q <= dataIn[FW-1:0];
    end

    assign fieldVal[g] = LO_W'(q);
  end

  always_comb begin
    emptyOffset = {fieldVal[FLD_EMPTY_HI][HI_W-1:0], fieldVal[FLD_EMPTY_LO]};
    fullOffset  = {fieldVal[FLD_FULL_HI][HI_W-1:0],  fieldVal[FLD_FULL_LO]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataOut <= '0;
    else if (strb.rdStb) dataOut <= fieldVal[strb.rdSel];
  end

  AST_OFS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> ($stable(emptyOffset) && $stable(fullOffset))); // R4
  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStb |=> $stable(dataOut)); // R7
  AST_EMPTY_LO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.wrSel == FLD_EMPTY_LO)
      |=> (emptyOffset[LO_W-1:0] == $past(dataIn))); // R2
  AST_FULL_HI_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.wrSel == FLD_FULL_HI)
      |=> (fullOffset[OFS_W-1:LO_W] == $past(dataIn[HI_W-1:0]))); // R2

endmodule

// File: rtl/ofs_seq.sv
module ofs_seq #(
  parameter int LO_W    = 8,
  parameter int HI_W    = 5,
  parameter int DEF_OFS = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ldN,
  input  logic                 wrEnN,
  input  logic [LO_W-1:0]      dataIn,
  input  logic                 rdEnAN,
  input  logic                 rdEnBN,
  output logic [LO_W-1:0]      dataOut,
  output logic [LO_W+HI_W-1:0] emptyOffset,
  output logic [LO_W+HI_W-1:0] fullOffset,
  output logic                 conflictErr
);

  ofs_seq_pkg::ofsStrobe_t strb;

  ofs_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ldN        (ldN),
    .wrEnN      (wrEnN),
    .rdEnAN     (rdEnAN),
    .rdEnBN     (rdEnBN),
    .strb       (strb),
    .conflictErr(conflictErr)
  );

  ofs_seq_dpath #(
    .LO_W   (LO_W),
    .HI_W   (HI_W),
    .DEF_OFS(DEF_OFS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .emptyOffset(emptyOffset),
    .fullOffset (fullOffset)
  );

  AST_RESET_VALUES: assert property (@(posedge clk)
    !rstN |=> (emptyOffset == 13'(DEF_OFS) && fullOffset == 13'(DEF_OFS)
               && dataOut == '0 && !conflictErr)); // R1

endmodule

// File: tb/ofs_seq_bench.sv
`timescale 1ns/1ps
module ofs_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldN = 1'b1;
  logic        wrEnN = 1'b1;
  logic [7:0]  dataIn = '0;
  logic        rdEnAN = 1'b1;
  logic        rdEnBN = 1'b1;
  logic [7:0]  dataOut;
  logic [12:0] emptyOffset;
  logic [12:0] fullOffset;
  logic        conflictErr;

  int total = 0;
  int bad = 0;

  // Model state, built from the requirements.
  logic [7:0] mFld [4];
  int         mWp;
  int         mRp;
  logic [7:0] mOut;
  logic       mErr;

  always #2.5 clk = ~clk;

  ofs_seq u_ofs_seq (
    .clk(clk), .rstN(rstN), .ldN(ldN), .wrEnN(wrEnN), .dataIn(dataIn),
    .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .dataOut(dataOut),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset), .conflictErr(conflictErr)
  );

  // Each entry: {ldN, wrEnN, rdEnAN, rdEnBN, dataIn}
  localparam logic [11:0] VEC [18] = '{
    {4'b0011, 8'hA3},  // write emptyLo
    {4'b0111, 8'h55},  // no-op (R4)
    {4'b1011, 8'hFF},  // ldN high (R4)
    {4'b0011, 8'hF3},  // write emptyHi, 5 bits kept
    {4'b1111, 8'h00},  // session ends (R5)
    {4'b0011, 8'h22},  // resume at fullLo (R5)
    {4'b0011, 8'h0C},  // fullHi
    {4'b0011, 8'hB4},  // wraps to emptyLo (R3)
    {4'b0100, 8'h00},  // read emptyLo (R6)
    {4'b0101, 8'h00},  // one enable high (R7)
    {4'b1100, 8'h00},  // ldN high (R7)
    {4'b0110, 8'h00},  // other enable high (R7)
    {4'b0100, 8'h00},  // read emptyHi
    {4'b0100, 8'h00},  // read fullLo
    {4'b0100, 8'h00},  // read fullHi
    {4'b0100, 8'h00},  // wrap to emptyLo
    {4'b0000, 8'h11},  // collision: write emptyHi only (R8)
    {4'b0100, 8'h00}   // read emptyHi (holds after collision)
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mFld[0] = 8'h07; mFld[1] = 8'h00; mFld[2] = 8'h07; mFld[3] = 8'h00;
    mWp = 0; mRp = 0; mOut = '0; mErr = 1'b0;
  endtask

  task automatic step(input logic rst, input logic [11:0] v);
    logic wr, rd;
    @(negedge clk);
    rstN = rst; {ldN, wrEnN, rdEnAN, rdEnBN, dataIn} = v;
    @(posedge clk);
    wr = !v[11] && !v[10];
    rd = !v[11] && !v[9] && !v[8];
    if (!rst) modelReset();
    else begin
      if (rd && !wr) begin mOut = mFld[mRp]; mRp = (mRp + 1) % 4; end
      if (wr) begin
        mFld[mWp] = (mWp % 2 == 1) ? {3'b000, v[4:0]} : v[7:0];
        mWp = (mWp + 1) % 4;
      end
      mErr = wr && rd;
    end
    #1;
  endtask

  task automatic checkAll(input string tag);
    chk(32'(emptyOffset), 32'({mFld[1][4:0], mFld[0]}), {tag, " emptyOffset"});
    chk(32'(fullOffset), 32'({mFld[3][4:0], mFld[2]}), {tag, " fullOffset"});
    chk(32'(dataOut), 32'(mOut), {tag, " dataOut"});
    chk(32'(conflictErr), 32'(mErr), {tag, " conflictErr"});
  endtask

  initial begin : watchdog
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    modelReset();
    step(1'b0, 12'hF00);
    step(1'b0, 12'hF00);
    // R1: reset values
    chk(32'(emptyOffset), 32'd7, "R1 emptyOffset");
    chk(32'(fullOffset), 32'd7, "R1 fullOffset");
    chk(32'(dataOut), 32'd0, "R1 dataOut");
    chk(32'(conflictErr), 32'd0, "R1 conflictErr");

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 18; i++) begin
      step(1'b1, VEC[i]);
      checkAll("R2/R3/R4/R5/R6/R7/R8 table");
    end
    // R8: flag clears one cycle after the collision
    chk(32'(conflictErr), 32'd0, "R8 flag cleared");

    // R1: reset mid-sequence returns both pointers to emptyLo
    step(1'b1, {4'b0011, 8'h44});      // write fullLo (wp was 2)
    step(1'b0, 12'hF00);
    checkAll("R1 mid reset");
    step(1'b1, {4'b0011, 8'h9E});      // must land in emptyLo
    chk(32'(emptyOffset), 32'h0009E, "R1 write pointer home");
    chk(32'(fullOffset), 32'd7, "R1 full untouched");
    step(1'b1, {4'b0100, 8'h00});      // must read emptyLo
    chk(32'(dataOut), 32'h9E, "R1 read pointer home");

    // R3: full cycle of five writes in one session
    step(1'b1, {4'b0011, 8'h01});      // emptyHi
    step(1'b1, {4'b0011, 8'h02});      // fullLo
    step(1'b1, {4'b0011, 8'hFF});      // fullHi -> 1F
    step(1'b1, {4'b0011, 8'h5A});      // wraps to emptyLo
    chk(32'(emptyOffset), 32'h015A, "R3 wrap emptyOffset");
    chk(32'(fullOffset), 32'h1F02, "R3 fullOffset max high");
    checkAll("R3 model");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule